// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for a single SDRAM read or write burst. A one-cycle start request carries a starting column, a 3-bit burst length code and an ordering select (sequential or interleaved). From the next clock on, the block presents one column per cycle with a valid flag, plus a flag that marks the final beat of a fixed-length burst.

A running burst can be cut short on any cycle, either by a terminate input or by a fresh start request, which begins a new sequence at once. A full-page burst never ends by itself. It wraps within the 256-column page until it is stopped. A start request with a reserved length code, or a full-page request in interleaved order, is refused. The refusal shows as a one-cycle error pulse and leaves any running burst as it was. Row and bank decoding, command generation and data movement belong to other blocks.

Top module: `burst_colgen`

## Requirements
- R1: After reset, valid_o, last_o and err_o are low, and they stay low until a start request is accepted.
- R2: A legal start request sampled at a rising edge makes valid_o high with col_o equal to start_col_i after that edge. The burst then advances by one beat per clock.
- R3: The length code len_code_i maps as 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page. A start with code 3'b100, 3'b101 or 3'b110 is refused: err_o is high for exactly the next cycle, and an idle or running burst continues unchanged.
- R4: A start with interleave_i = 1 and code 3'b111 is refused in the same way as in R3.
- R5: In sequential order (interleave_i = 0), beat i outputs the start column with its low log2(BL) bits replaced by (start + i) mod BL. The upper bits stay equal to the start column.
- R6: In interleaved order (interleave_i = 1), beat i outputs the start column with its low log2(BL) bits XORed with i.
- R7: For fixed lengths, last_o is high only on beat BL-1. valid_o drops after that beat unless a new legal start is sampled on that edge.
- R8: A full-page burst outputs (start + i) mod 256, never raises last_o, and runs until it is terminated or restarted.
- R9: term_i sampled high during a burst, with no legal start on the same edge, makes valid_o low after that edge. term_i while idle has no effect.
- R10: A legal start sampled during a burst replaces it on that edge with beat 0 of the new burst. A legal start takes priority over term_i on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, one cycle |
| start_col_i | input | COL_W (8) | Starting column address |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W (8) | Column address of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |
| err_o | output | 1 | Previous cycle's start request was refused |

## Verification
The bench builds the block with COL_W = 8, which gives a 256-column page. At this size a full-page burst can be driven across the page boundary within a few cycles (start at 0xFC), so the wrap from 0xFF to 0x00 and the absence of last_o can both be seen. The narrow page also keeps the upper column bits small enough that runs in both orderings show those bits held fixed while the low bits rotate. The burst is restarted mid-run, restarted on the same edge as a terminate, and sent refused requests while it is running.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             legal_o
);
    logic known;

    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        known  = 1'b1;
        case (code_i)
            LEN_ONE:   mask_o = '0;
            LEN_TWO:   mask_o = COL_W'(1);
            LEN_FOUR:  mask_o = COL_W'(3);
            LEN_EIGHT: mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:   known  = 1'b0;
        endcase
        legal_o = known && !(full_o && ilv_i);
    end

    // R4: interleaved full page is never legal
    always_comb begin
        if (ilv_i && code_i == LEN_PAGE) begin
            a_ilv_page_illegal_r4: assert (!legal_o);
        end
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    always_comb begin
        sum = base_i + beat_i;
        if (ilv_i) begin
            col_o = base_i ^ (beat_i & mask_i);
        end else begin
            col_o = (base_i & ~mask_i) | (sum & mask_i);
        end
    end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    typedef struct packed {
        logic             valid;
        logic             last;
        logic             err;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] col;
    } st_t;

    st_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_legal;
    logic [COL_W-1:0] beat_nx;
    logic [COL_W-1:0] col_nx;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i  (len_code_i),
        .ilv_i   (interleave_i),
        .mask_o  (dec_mask),
        .full_o  (dec_full),
        .legal_o (dec_legal)
    );

    assign beat_nx = st_q.beat + COL_W'(1);

    burst_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (st_q.base),
        .beat_i (beat_nx),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (start_i && dec_legal) begin
            st_d.valid = 1'b1;
            st_d.base  = start_col_i;
            st_d.beat  = '0;
            st_d.mask  = dec_mask;
            st_d.full  = dec_full;
            st_d.ilv   = interleave_i;
            st_d.col   = start_col_i;
            st_d.last  = !dec_full && (dec_mask == '0);
        end else begin
            st_d.err = start_i;
            if (term_i || !st_q.valid || st_q.last) begin
                st_d.valid = 1'b0;
                st_d.last  = 1'b0;
            end else begin
                st_d.beat = beat_nx;
                st_d.col  = col_nx;
                st_d.last = !st_q.full && (beat_nx == st_q.mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.valid;
    assign last_o  = st_q.last;
    assign err_o   = st_q.err;

    // R2: accepted start shows its column on the next cycle
    p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dec_legal) |=> (valid_o && col_o == $past(start_col_i)));

    // R3: refused start raises the error pulse
    p_reject_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !dec_legal) |=> err_o);

    // R5: upper column bits never move during a burst
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (((col_o ^ st_q.base) & ~st_q.mask) == '0));

    // R7: the burst ends after its last beat
    p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);

    // R7: last only with a valid beat
    p_idle_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !last_o);

    // R8: full page never flags a last beat
    p_page_no_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.full) |-> !last_o);

    // R9: terminate without a legal start stops the burst
    p_term_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !(start_i && dec_legal)) |=> !valid_o);
endmodule

// File: tb/burst_colgen_test.sv
module burst_colgen_test;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = 3'b000;
    logic             interleave_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             err_o;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_active = 1'b0;
    bit m_err    = 1'b0;
    bit m_ilv    = 1'b0;
    int m_base   = 0;
    int m_i      = 0;
    int m_bl     = 1;

    always #5 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .term_i       (term_i),
        .col_o        (col_o),
        .valid_o      (valid_o),
        .last_o       (last_o),
        .err_o        (err_o)
    );

    function automatic int code_len(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        int bl;
        bit ok;
        if (!rst_n) begin
            m_active = 1'b0;
            m_err    = 1'b0;
        end else begin
            bl    = code_len(len_code_i);
            ok    = (bl >= 0) && !(bl == 0 && interleave_i);
            m_err = 1'b0;
            if (start_i && ok) begin
                m_active = 1'b1;
                m_base   = int'(start_col_i);
                m_i      = 0;
                m_bl     = bl;
                m_ilv    = interleave_i;
            end else begin
                if (start_i) m_err = 1'b1;
                if (term_i) m_active = 1'b0;
                else if (m_active) begin
                    if (m_bl != 0 && m_i == m_bl - 1) m_active = 1'b0;
                    else m_i++;
                end
            end
        end
    end

    function automatic int exp_col();
        if (m_bl == 0) return (m_base + m_i) % 256;
        if (m_ilv) return m_base ^ m_i;
        return (m_base - (m_base % m_bl)) + (((m_base % m_bl) + m_i) % m_bl);
    endfunction

    task automatic check_bit(input string what, input logic act, input bit expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", cur_req, what, act, expv);
        end
    endtask

    task automatic compare();
        bit e_last;
        e_last = m_active && m_bl != 0 && m_i == m_bl - 1;
        check_bit("valid_o", valid_o, m_active);
        check_bit("err_o", err_o, m_err);
        check_bit("last_o", last_o, e_last);
        if (m_active) begin
            checks++;
            if (int'(col_o) != exp_col()) begin
                fails++;
                $display("FAIL %s col_o: actual=%0h expected=%0h", cur_req, col_o, exp_col());
            end
        end
    endtask

    // drive inputs for one edge, then compare after it
    task automatic tick(input bit s, input int col, input logic [2:0] code,
                        input bit ilv, input bit t);
        start_i      = s;
        start_col_i  = COL_W'(col);
        len_code_i   = code;
        interleave_i = ilv;
        term_i       = t;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 0, 3'b000, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        idle(2);

        cur_req = "R5";   // seq BL4 from 0x1E: 1E 1F 1C 1D
        tick(1'b1, 'h1E, 3'b010, 1'b0, 1'b0);
        idle(5);

        cur_req = "R6";   // interleaved BL8 from 0x35
        tick(1'b1, 'h35, 3'b011, 1'b1, 1'b0);
        idle(9);

        cur_req = "R7";   // BL1, BL2 interleaved, seq BL8
        tick(1'b1, 'h42, 3'b000, 1'b0, 1'b0);
        idle(2);
        tick(1'b1, 'h43, 3'b001, 1'b1, 1'b0);
        idle(3);
        tick(1'b1, 'hA9, 3'b011, 1'b0, 1'b0);
        idle(9);

        cur_req = "R8";   // full page wrap from 0xFC
        tick(1'b1, 'hFC, 3'b111, 1'b0, 1'b0);
        idle(12);
        cur_req = "R9";
        tick(1'b0, 0, 3'b000, 1'b0, 1'b1);
        idle(2);
        tick(1'b0, 0, 3'b000, 1'b0, 1'b1);   // idle terminate
        idle(1);

        cur_req = "R3";   // reserved codes idle and mid-burst
        tick(1'b1, 'h10, 3'b101, 1'b0, 1'b0);
        idle(2);
        tick(1'b1, 'h60, 3'b011, 1'b0, 1'b0);
        idle(2);
        tick(1'b1, 'h00, 3'b100, 1'b0, 1'b0);
        tick(1'b1, 'h00, 3'b110, 1'b1, 1'b0);
        idle(6);

        cur_req = "R4";   // interleaved full page refused
        tick(1'b1, 'h20, 3'b111, 1'b1, 1'b0);
        idle(2);
        tick(1'b1, 'h70, 3'b010, 1'b1, 1'b0);
        tick(1'b1, 'h20, 3'b111, 1'b1, 1'b0);
        idle(4);

        cur_req = "R10";  // restart mid-burst, start beats term
        tick(1'b1, 'h80, 3'b011, 1'b0, 1'b0);
        idle(3);
        tick(1'b1, 'h93, 3'b010, 1'b1, 1'b0);
        idle(1);
        tick(1'b1, 'hC6, 3'b011, 1'b0, 1'b1);
        idle(2);
        cur_req = "R2";
        tick(1'b1, 'hD1, 3'b111, 1'b0, 1'b0);
        idle(3);
        tick(1'b1, 'h07, 3'b001, 1'b0, 1'b0);
        idle(4);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule